// File: doc/BRIEF.md
# Last-Level Cache Bank Coherence Controller with Token Counting

This block is one bank of a shared last-level cache. Each line keeps its coherence record in the tag array, next to the data. The record holds a data state, a vector of sharer cores, the core that holds the owner token, and a count of the tokens the bank itself holds. Every block has a fixed total of tokens, equal to the number of cores. A reader needs at least one token and a writer needs all of them.

A request that misses allocates a line in one of three construction states and asks memory for the block. Which state it takes depends on whether the request is a read, a write or an instruction fetch. For a read or a write, the memory fill goes to the requestor with every token. For an instruction fetch, the fill is split: the requestor gets one token, and the bank keeps the rest together with the owner token. Later fetches of that block are then served straight from the bank.

Lines whose data has moved into private caches keep only sharing information. Such lines are dropped silently when they are replaced. A replaced line that holds tokens writes its tokens, and its data when it owns the block, back to memory. Private caches return blocks with a data put message, and the bank picks the resulting data state from the tokens, the ownership and the dirtiness carried by that message.

Top module: `llc_coh_ctrl`

## Requirements
- R1: After reset every line is invalid, rsp_kind is 0 (none), wb_valid is 0 and fwd_mask is 0. Message codes on msg_type are: 0 read, 1 write, 2 instruction fetch, 3 memory fill, 4 token info, 5 unblock, 6 data put. Codes on rsp_kind are: 0 none, 1 memory request, 2 data, 3 forward, 4 stall.
- R2: A read, write or fetch that misses allocates a line in its matching construction state. One cycle later the bank answers with rsp_kind 1, and rsp_core names the requestor.
- R3: A memory fill for a line built by a read or a write returns data to the pending requestor with all tokens and the owner flag set. An unblock from that requestor then leaves the line with sharing information only and no bank tokens.
- R4: A memory fill for a fetch-built line returns data with one token and no owner flag. The requestor's unblock moves the line to Owned, holding all other tokens, so a later fetch gets data with one token directly from the bank.
- R5: A request or data put that hits a line under construction receives rsp_kind 4. The line is left unchanged.
- R6: A read or fetch that hits a sharing-only line is forwarded, with fwd_mask set to the bit of the owner core. A write that hits such a line is forwarded, with fwd_mask set to every sharer except the requestor. The requestor then becomes the sole sharer and the owner.
- R7: A read that hits a token-holding line that has all tokens receives every token. A fetch, or a read of a partially filled line, receives one token. The owner flag is passed along only when the bank gives up its last token while it owns the block, and the line keeps Owned or Shared while tokens remain.
- R8: A write that hits a token-holding line receives all of the bank's tokens and its owner flag. fwd_mask names the other sharers, and the line keeps sharing information only.
- R9: A data put adds its tokens to the line and removes the sender from the sharers. The line becomes Modified when it then holds all tokens and the put is dirty, Owned when the bank holds the owner token, and Shared otherwise.
- R10: Allocation uses the lowest-numbered invalid way first. Failing that, it takes the least recently used sharing-only way, and after that the least recently used token-holding way. Lines under construction are never chosen. When no way can be chosen, the message receives rsp_kind 4.
- R11: Replacing a sharing-only line raises no write-back. Replacing a token-holding line raises wb_valid with the line's address and token count, and wb_data is set when the bank owned the block.
- R12: Token info adds the sender to the line's sharers and makes it the owner when msg_own is set. On a miss, token info is ignored.
- R13: A memory fill or unblock that matches no line waiting for it produces no response and leaves state unchanged. This covers a wrong core, a line that is not under construction, or an unblock that arrives before the fill.
- R14: Every accepted request or put that hits or allocates makes its way the most recently used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Incoming message present this cycle |
| msg_type | input | 3 | Message code (R1) |
| msg_addr | input | AW | Block address |
| msg_core | input | CIW | Sending or requesting core |
| msg_tokens | input | TW | Tokens carried by a data put |
| msg_own | input | 1 | Message carries or reports the owner token |
| msg_dirty | input | 1 | Data put carries modified data |
| rsp_kind | output | 3 | Response code (R1), registered |
| rsp_core | output | CIW | Core the response is addressed to |
| rsp_tokens | output | TW | Tokens sent with a data response |
| rsp_own | output | 1 | Owner token sent with a data response |
| fwd_mask | output | CORES | Cores that must forward or give up their copies |
| wb_valid | output | 1 | Eviction write-back to memory |
| wb_addr | output | AW | Address of the evicted block |
| wb_tokens | output | TW | Tokens returned to memory |
| wb_data | output | 1 | Write-back includes the owner's data |

## Verification
The assertions rely on the neighbours to conserve tokens. A data put never pushes a line past the total token count, and a put carries the owner flag only when the bank does not already own the block. The bench stays inside these limits by consulting its own model of each line before it issues a put: it sizes the token count to the room left, clears the owner flag when the bank already owns the block, and turns a put aimed at a full line into a read. Random fills, unblocks and token info go to arbitrary addresses and cores, so the ignore rules are exercised. Unblocks still favour the pending core, so that construction completes often.

// File: rtl/llc_coh_ctrl.sv
module llc_coh_ctrl #(
  parameter int WAYS  = 4,
  parameter int CORES = 4,
  parameter int AW    = 8,
  localparam int CIW  = (CORES > 1) ? $clog2(CORES) : 1,
  localparam int TW   = $clog2(CORES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_valid,
  input  logic [2:0]       msg_type,
  input  logic [AW-1:0]    msg_addr,
  input  logic [CIW-1:0]   msg_core,
  input  logic [TW-1:0]    msg_tokens,
  input  logic             msg_own,
  input  logic             msg_dirty,
  output logic [2:0]       rsp_kind,
  output logic [CIW-1:0]   rsp_core,
  output logic [TW-1:0]    rsp_tokens,
  output logic             rsp_own,
  output logic [CORES-1:0] fwd_mask,
  output logic             wb_valid,
  output logic [AW-1:0]    wb_addr,
  output logic [TW-1:0]    wb_tokens,
  output logic             wb_data
);
  localparam int WIW = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam logic [TW-1:0] TALL = TW'(CORES);
  localparam logic [2:0] M_GETS = 3'd0, M_GETX = 3'd1, M_IFET = 3'd2, M_FILL = 3'd3,
                         M_TINF = 3'd4, M_UNBL = 3'd5, M_PUT = 3'd6;
  localparam logic [2:0] K_NONE = 3'd0, K_MREQ = 3'd1, K_DATA = 3'd2, K_FWD = 3'd3, K_STALL = 3'd4;

  typedef enum logic [2:0] {ST_I, ST_A, ST_S, ST_O, ST_M, ST_CS, ST_CX, ST_CI} st_e;

  function automatic logic is_con(st_e s);
    return s == ST_CS || s == ST_CX || s == ST_CI;
  endfunction
  function automatic logic is_dat(st_e s);
    return s == ST_S || s == ST_O || s == ST_M;
  endfunction

  st_e            st   [WAYS];
  logic [AW-1:0]  tag  [WAYS];
  logic [CORES-1:0] shr[WAYS];
  logic [CIW-1:0] own  [WAYS];
  logic [CIW-1:0] pend [WAYS];
  logic [TW-1:0]  tok  [WAYS];
  logic           fill [WAYS];
  logic [WIW-1:0] age  [WAYS];

  logic hit, ifnd, afnd, dfnd, vf;
  logic [WIW-1:0] hw, iw, aw, dw, vw, tw, a_age, d_age;

  always_comb begin
    hit = 1'b0; hw = '0; ifnd = 1'b0; iw = '0;
    afnd = 1'b0; aw = '0; a_age = '0; dfnd = 1'b0; dw = '0; d_age = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (st[w] != ST_I && tag[w] == msg_addr) begin hit = 1'b1; hw = WIW'(w); end
      if (st[w] == ST_I && !ifnd) begin ifnd = 1'b1; iw = WIW'(w); end
      if (st[w] == ST_A && (!afnd || age[w] > a_age)) begin afnd = 1'b1; aw = WIW'(w); a_age = age[w]; end
      if (is_dat(st[w]) && (!dfnd || age[w] > d_age)) begin dfnd = 1'b1; dw = WIW'(w); d_age = age[w]; end
    end
  end

  assign vf = ifnd | afnd | dfnd;
  assign vw = ifnd ? iw : (afnd ? aw : dw);

  st_e hst;
  logic hcon, hown, is_req, is_put, acc, blocked, alloc, touch, evd;
  logic [TW-1:0] give, rem, psum;
  logic [CORES-1:0] src;
  st_e pst;

  assign hst     = st[hw];
  assign hcon    = hit && is_con(hst);
  assign hown    = hit && (hst == ST_O || hst == ST_M);
  assign is_req  = msg_valid && (msg_type == M_GETS || msg_type == M_GETX || msg_type == M_IFET);
  assign is_put  = msg_valid && msg_type == M_PUT;
  assign acc     = is_req || is_put;
  assign blocked = acc && (hcon || (!hit && !vf));
  assign alloc   = acc && !hit && vf;
  assign touch   = acc && !blocked;
  assign tw      = hit ? hw : vw;
  assign evd     = is_dat(st[vw]);
  assign src     = CORES'(1) << msg_core;
  assign give    = (msg_type == M_GETS && tok[hw] == TALL) ? TALL : TW'(1);
  assign rem     = tok[hw] - give;
  assign psum    = (hit ? tok[hw] : '0) + msg_tokens;
  assign pst     = (psum == TALL && msg_dirty) ? ST_M : ((hown || msg_own) ? ST_O : ST_S);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < WAYS; w++) begin
        st[w] <= ST_I; tag[w] <= '0; shr[w] <= '0; own[w] <= '0;
        pend[w] <= '0; tok[w] <= '0; fill[w] <= 1'b0; age[w] <= WIW'(w);
      end
      rsp_kind <= K_NONE; rsp_core <= '0; rsp_tokens <= '0; rsp_own <= 1'b0;
      fwd_mask <= '0; wb_valid <= 1'b0; wb_addr <= '0; wb_tokens <= '0; wb_data <= 1'b0;
    end else begin
      rsp_kind <= K_NONE; rsp_core <= msg_core; rsp_tokens <= '0; rsp_own <= 1'b0;
      fwd_mask <= '0; wb_valid <= 1'b0;
      wb_addr <= tag[vw]; wb_tokens <= tok[vw]; wb_data <= (st[vw] == ST_O || st[vw] == ST_M);
      if (touch)
        for (int w = 0; w < WAYS; w++)
          if (WIW'(w) == tw) age[w] <= '0;
          else if (age[w] < age[tw]) age[w] <= age[w] + 1'b1;
      if (blocked) begin
        rsp_kind <= K_STALL;
      end else if (alloc) begin
        tag[vw] <= msg_addr; shr[vw] <= '0; own[vw] <= msg_core;
        pend[vw] <= msg_core; fill[vw] <= 1'b0; wb_valid <= evd;
        if (is_put) begin
          tok[vw] <= msg_tokens; st[vw] <= pst;
        end else begin
          tok[vw] <= '0; rsp_kind <= K_MREQ;
          st[vw] <= (msg_type == M_GETS) ? ST_CS : ((msg_type == M_GETX) ? ST_CX : ST_CI);
        end
      end else if (hit && is_put) begin
        tok[hw] <= psum; st[hw] <= pst; shr[hw] <= shr[hw] & ~src;
      end else if (hit && is_req && hst == ST_A) begin
        rsp_kind <= K_FWD;
        if (msg_type == M_GETX) begin
          fwd_mask <= shr[hw] & ~src; shr[hw] <= src; own[hw] <= msg_core;
        end else begin
          fwd_mask <= CORES'(1) << own[hw]; shr[hw] <= shr[hw] | src;
        end
      end else if (hit && is_req) begin
        rsp_kind <= K_DATA;
        if (msg_type == M_GETX) begin
          rsp_tokens <= tok[hw]; rsp_own <= hown; fwd_mask <= shr[hw] & ~src;
          st[hw] <= ST_A; shr[hw] <= src; own[hw] <= msg_core; tok[hw] <= '0;
        end else begin
          rsp_tokens <= give; rsp_own <= (rem == '0) && hown; tok[hw] <= rem;
          shr[hw] <= (give == TALL) ? src : (shr[hw] | src);
          if (rem == '0) begin
            st[hw] <= ST_A;
            if (hown) own[hw] <= msg_core;
          end else begin
            st[hw] <= hown ? ST_O : ST_S;
          end
        end
      end else if (msg_valid && hcon && msg_type == M_FILL && !fill[hw]) begin
        fill[hw] <= 1'b1; rsp_kind <= K_DATA; rsp_core <= pend[hw];
        if (hst == ST_CI) begin
          rsp_tokens <= TW'(1); tok[hw] <= TALL - TW'(1);
        end else begin
          rsp_tokens <= TALL; rsp_own <= 1'b1;
        end
      end else if (msg_valid && hcon && msg_type == M_UNBL && fill[hw] && pend[hw] == msg_core) begin
        if (hst == ST_CX) shr[hw] <= src;
        else shr[hw] <= shr[hw] | src;
        if (hst == ST_CI) st[hw] <= ST_O;
        else begin st[hw] <= ST_A; own[hw] <= msg_core; end
      end else if (msg_valid && hit && msg_type == M_TINF) begin
        shr[hw] <= shr[hw] | src;
        if (msg_own) own[hw] <= msg_core;
      end
    end
  end

  AST_DATA_HAS_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_kind == K_DATA |-> rsp_tokens != '0); // R7
  AST_WB_HAS_TOKENS: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> wb_tokens != '0); // R11
  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_kind == K_STALL |-> (!wb_valid && fwd_mask == '0)); // R5
  AST_MISS_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    (is_req && !hit) |=> (rsp_kind == K_MREQ || rsp_kind == K_STALL)); // R2
  AST_CON_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && hcon) |=> rsp_kind == K_STALL); // R5

  for (genvar g = 0; g < WAYS; g++) begin : g_chk
    AST_A_NO_TOKENS: assert property (@(posedge clk) disable iff (!rst_n)
      st[g] == ST_A |-> tok[g] == '0); // R3
    AST_M_ALL_TOKENS: assert property (@(posedge clk) disable iff (!rst_n)
      st[g] == ST_M |-> tok[g] == TALL); // R9
    AST_TOKEN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      tok[g] <= TALL); // R9
  end
endmodule

// File: tb/llc_coh_ctrl_tb.sv
`timescale 1ns/1ps
module llc_coh_ctrl_tb_top;
  localparam int W = 4, C = 4, AW = 8, T = C;
  logic clk = 1'b0, rst_n = 1'b0;
  logic msg_valid = 1'b0, msg_own = 1'b0, msg_dirty = 1'b0;
  logic [2:0] msg_type = '0;
  logic [AW-1:0] msg_addr = '0;
  logic [1:0] msg_core = '0;
  logic [2:0] msg_tokens = '0;
  logic [2:0] rsp_kind, rsp_tokens, wb_tokens;
  logic [1:0] rsp_core;
  logic rsp_own, wb_valid, wb_data;
  logic [C-1:0] fwd_mask;
  logic [AW-1:0] wb_addr;

  llc_coh_ctrl #(.WAYS(W), .CORES(C), .AW(AW)) dut_i (
    .clk, .rst_n, .msg_valid, .msg_type, .msg_addr, .msg_core, .msg_tokens, .msg_own,
    .msg_dirty, .rsp_kind, .rsp_core, .rsp_tokens, .rsp_own, .fwd_mask, .wb_valid,
    .wb_addr, .wb_tokens, .wb_data);

  always #4 clk = ~clk;

  int vectors = 0, errors = 0;
  bit finished = 0;
  int m_st[W], m_tag[W], m_sh[W], m_own[W], m_pend[W], m_tok[W], m_fill[W], m_age[W];
  int e_kind, e_core, e_tok, e_own, e_mask, e_wb, e_wba, e_wbt, e_wbd;

  function automatic bit con(int s); return s >= 5; endfunction
  function automatic bit dat(int s); return s >= 2 && s <= 4; endfunction

  function automatic int find_hit(int a);
    for (int w = 0; w < W; w++) if (m_st[w] != 0 && m_tag[w] == a) return w;
    return -1;
  endfunction

  task automatic model(input int t, a, c, k, o, d);
    int hw, vw, best, tw, sb, give, rem, psum, pst;
    bit acc, blocked, hown;
    hw = find_hit(a);
    vw = -1;
    for (int w = W - 1; w >= 0; w--) if (m_st[w] == 0) vw = w;
    if (vw < 0) begin
      best = -1;
      for (int w = 0; w < W; w++) if (m_st[w] == 1 && m_age[w] > best) begin best = m_age[w]; vw = w; end
    end
    if (vw < 0) begin
      best = -1;
      for (int w = 0; w < W; w++) if (dat(m_st[w]) && m_age[w] > best) begin best = m_age[w]; vw = w; end
    end
    acc = (t <= 2) || (t == 6);
    blocked = acc && ((hw >= 0 && con(m_st[hw])) || (hw < 0 && vw < 0));
    hown = hw >= 0 && (m_st[hw] == 3 || m_st[hw] == 4);
    sb = 1 << c;
    e_kind = 0; e_core = c; e_tok = 0; e_own = 0; e_mask = 0; e_wb = 0; e_wba = 0; e_wbt = 0; e_wbd = 0;
    if (acc && !blocked) begin
      tw = (hw >= 0) ? hw : vw;
      for (int w = 0; w < W; w++)
        if (w != tw && m_age[w] < m_age[tw]) m_age[w]++;
      m_age[tw] = 0;
    end
    psum = ((hw >= 0) ? m_tok[hw] : 0) + k;
    pst = (psum == T && d) ? 4 : ((hown || o) ? 3 : 2);
    if (blocked) e_kind = 4;
    else if (acc && hw < 0) begin
      if (dat(m_st[vw])) begin
        e_wb = 1; e_wba = m_tag[vw]; e_wbt = m_tok[vw]; e_wbd = (m_st[vw] >= 3);
      end
      m_tag[vw] = a; m_sh[vw] = 0; m_own[vw] = c; m_pend[vw] = c; m_fill[vw] = 0;
      if (t == 6) begin m_tok[vw] = k; m_st[vw] = pst; end
      else begin m_tok[vw] = 0; m_st[vw] = 5 + t; e_kind = 1; end
    end else if (t == 6) begin
      m_tok[hw] = psum; m_st[hw] = pst; m_sh[hw] &= ~sb;
    end else if (acc && m_st[hw] == 1) begin
      e_kind = 3;
      if (t == 1) begin e_mask = m_sh[hw] & ~sb; m_sh[hw] = sb; m_own[hw] = c; end
      else begin e_mask = 1 << m_own[hw]; m_sh[hw] |= sb; end
    end else if (acc) begin
      e_kind = 2;
      if (t == 1) begin
        e_tok = m_tok[hw]; e_own = hown; e_mask = m_sh[hw] & ~sb;
        m_st[hw] = 1; m_sh[hw] = sb; m_own[hw] = c; m_tok[hw] = 0;
      end else begin
        give = (t == 0 && m_tok[hw] == T) ? T : 1;
        rem = m_tok[hw] - give;
        e_tok = give; e_own = (rem == 0) && hown; m_tok[hw] = rem;
        m_sh[hw] = (give == T) ? sb : (m_sh[hw] | sb);
        if (rem == 0) begin m_st[hw] = 1; if (hown) m_own[hw] = c; end
        else m_st[hw] = hown ? 3 : 2;
      end
    end else if (hw >= 0 && con(m_st[hw]) && t == 3 && !m_fill[hw]) begin
      m_fill[hw] = 1; e_kind = 2; e_core = m_pend[hw];
      if (m_st[hw] == 7) begin e_tok = 1; m_tok[hw] = T - 1; end
      else begin e_tok = T; e_own = 1; end
    end else if (hw >= 0 && con(m_st[hw]) && t == 5 && m_fill[hw] && m_pend[hw] == c) begin
      if (m_st[hw] == 6) m_sh[hw] = sb; else m_sh[hw] |= sb;
      if (m_st[hw] == 7) m_st[hw] = 3;
      else begin m_st[hw] = 1; m_own[hw] = c; end
    end else if (hw >= 0 && t == 4) begin
      m_sh[hw] |= sb;
      if (o) m_own[hw] = c;
    end
  endtask

  task automatic fail_line(input string tag);
    errors++;
    $display("FAIL %s: kind=%0d core=%0d tok=%0d own=%0d mask=%b wb=%0d/%0h/%0d/%0d expected kind=%0d core=%0d tok=%0d own=%0d mask=%b wb=%0d/%0h/%0d/%0d",
      tag, rsp_kind, rsp_core, rsp_tokens, rsp_own, fwd_mask, wb_valid, wb_addr, wb_tokens, wb_data,
      e_kind, e_core, e_tok, e_own, e_mask[C-1:0], e_wb, e_wba, e_wbt, e_wbd);
  endtask

  task automatic send(input int t, a, c, k, o, d, input string tag);
    bit bad;
    model(t, a, c, k, o, d);
    msg_valid = 1'b1; msg_type = 3'(t); msg_addr = AW'(a); msg_core = 2'(c);
    msg_tokens = 3'(k); msg_own = 1'(o); msg_dirty = 1'(d);
    @(negedge clk);
    msg_valid = 1'b0;
    vectors++;
    bad = (rsp_kind != 3'(e_kind)) || (fwd_mask != C'(e_mask)) || (wb_valid != 1'(e_wb));
    if (e_kind != 0 && rsp_core != 2'(e_core)) bad = 1;
    if (e_kind == 2 && (rsp_tokens != 3'(e_tok) || rsp_own != 1'(e_own))) bad = 1;
    if (e_wb && (wb_addr != AW'(e_wba) || wb_tokens != 3'(e_wbt) || wb_data != 1'(e_wbd))) bad = 1;
    if (bad) fail_line(tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; msg_valid = 1'b0;
    for (int w = 0; w < W; w++) begin
      m_st[w] = 0; m_tag[w] = 0; m_sh[w] = 0; m_own[w] = 0; m_pend[w] = 0;
      m_tok[w] = 0; m_fill[w] = 0; m_age[w] = w;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd7));
    do_reset();
    vectors++;
    if (rsp_kind != 0 || wb_valid || fwd_mask != 0) begin
      e_kind = 0; e_mask = 0; e_wb = 0; fail_line("R1 reset");
    end
    send(0, 1, 0, 0, 0, 0, "R1 first miss");
    send(0, 1, 2, 0, 0, 0, "R5 read under construction");
    send(5, 1, 0, 0, 0, 0, "R13 unblock before fill");
    send(3, 1, 0, 0, 0, 0, "R3 read fill all tokens");
    send(5, 1, 3, 0, 0, 0, "R13 unblock wrong core");
    send(5, 1, 0, 0, 0, 0, "R3 unblock");
    send(0, 1, 1, 0, 0, 0, "R6 read forward to owner");
    send(4, 1, 2, 0, 1, 0, "R12 token info owner");
    send(1, 1, 3, 0, 0, 0, "R6 write forward to sharers");
    send(4, 9, 1, 0, 0, 0, "R12 token info miss");
    send(3, 9, 1, 0, 0, 0, "R13 fill miss");
    send(2, 2, 1, 0, 0, 0, "R2 fetch miss");
    send(3, 2, 0, 0, 0, 0, "R4 fetch fill one token");
    send(5, 2, 1, 0, 0, 0, "R4 unblock to owned");
    send(2, 2, 3, 0, 0, 0, "R4 fetch served by bank");
    send(1, 2, 0, 0, 0, 0, "R8 write on token line");
    send(6, 5, 2, 4, 0, 1, "R9 dirty full put");
    send(2, 5, 1, 0, 0, 0, "R7 fetch one token");
    send(0, 5, 3, 0, 0, 0, "R7 partial read one token");
    send(6, 5, 3, 2, 0, 0, "R9 put back");
    do_reset();
    send(6, 10, 0, 4, 0, 1, "R9 put fill");
    send(6, 11, 0, 4, 0, 0, "R9 put clean");
    send(6, 12, 1, 2, 0, 0, "R9 put shared");
    send(6, 13, 1, 3, 1, 0, "R9 put owned");
    send(0, 11, 0, 0, 0, 0, "R7 read all tokens");
    send(2, 10, 2, 0, 0, 0, "R14 touch way");
    send(0, 14, 3, 0, 0, 0, "R11 silent sharing-only victim");
    send(0, 15, 3, 0, 0, 0, "R10 LRU token victim");
    send(1, 16, 3, 0, 0, 0, "R11 write-back victim");
    send(6, 17, 3, 1, 0, 0, "R10 put allocates");
    do_reset();
    for (int i = 0; i < 4; i++) send(0, 20 + i, i, 0, 0, 0, "R2 fill ways");
    send(0, 30, 0, 0, 0, 0, "R10 no victim stall");
    send(6, 31, 0, 1, 0, 0, "R10 put no victim stall");
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      int t, a, c, k, o, d, hw;
      t = $urandom % 7; a = $urandom % 6; c = $urandom % 4;
      k = 0; o = $urandom % 2; d = $urandom % 2;
      hw = find_hit(a);
      if (t == 5 && hw >= 0 && ($urandom % 4) != 0) c = m_pend[hw];
      if (t == 6) begin
        int cur;
        cur = (hw >= 0 && dat(m_st[hw])) ? m_tok[hw] : 0;
        if (cur >= T) t = 0;
        else begin
          k = 1 + ($urandom % (T - cur));
          if (hw >= 0 && (m_st[hw] == 3 || m_st[hw] == 4)) o = 0;
        end
      end
      case (t)
        0: send(t, a, c, k, o, d, "R7 random read");
        1: send(t, a, c, k, o, d, "R8 random write");
        2: send(t, a, c, k, o, d, "R4 random fetch");
        3: send(t, a, c, k, o, d, "R3 random fill");
        4: send(t, a, c, k, o, d, "R12 random token info");
        5: send(t, a, c, k, o, d, "R13 random unblock");
        default: send(t, a, c, k, o, d, "R9 random put");
      endcase
    end
    summary();
  end
endmodule